// File: doc/BRIEF.md
# Ethernet receive address filter

This block gives an accept or drop verdict for every received Ethernet frame. It reads the destination and source addresses one byte per transfer. It then applies a set of enable bits that the CPU programs, and compares the addresses against a 48-bit station address. The MAC strobes `frame_start` once per frame and then streams the twelve address bytes in wire order: six destination bytes, then six source bytes. The verdict appears for a single cycle after the last of those bytes is taken. The MAC uses it to keep or discard the rest of the frame.

The byte input is a valid/ready stream, and a byte moves only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high only while a frame is being collected. It is low when the receiver is idle or stopped, and low in any cycle that carries an accepted frame-start strobe. A byte offered while `s_ready` is low is not consumed and has no effect. The source may drop `s_valid` between bytes for any number of cycles, and the block waits.

Address-filter rules:
- Broadcast, multicast and unicast frames each have their own enable bit.
- A receive-all bit accepts every frame.
- An inverse bit changes the unicast rule so that it accepts frames that are not addressed to the station.
- A source-address filter drops frames that claim to come from the station itself, and this drop overrides every accept rule.

Receiver enable and status:
- The receiver-enable bit starts the receiver at once.
- Clearing the bit stops the receiver only at a frame boundary, so a frame that is already in progress still gets its verdict.
- The `running` output shows whether the receiver is running or stopped.

Top module: `rx_addr_filter`

## Requirements
- R1: With `en_bcast` set, a frame whose destination is all ones (FF:FF:FF:FF:FF:FF) is accepted.
- R2: With `en_mcast` set, a frame is accepted when the group bit is set, and broadcast frames count as multicast for this rule. The group bit is bit 0 of the first destination byte received. Bit 0 of any other byte is not the group bit.
- R3: With `en_ucast` set and `inv_filter` clear, a frame with the group bit clear is accepted only if its destination equals `station_addr`. The station address maps to the wire as follows: the first byte on the wire is `station_addr[47:40]` and the sixth is `station_addr[7:0]`.
- R4: With `en_all` set, every frame is accepted whatever its destination, unless R6 drops it.
- R5: With `inv_filter` and `en_ucast` both set, a frame with the group bit clear is accepted only if its destination differs from `station_addr`. Group-addressed frames still follow R1 and R2.
- R6: With `sa_filter` set, a frame whose source address equals `station_addr` gets `verdict_accept` = 0, whatever R1 to R5 would give.
- R7: `verdict_valid` is high for exactly one cycle, in the cycle right after the clock edge that takes the twelfth address byte. `verdict_accept` is meaningful in that cycle.
- R8: `running` goes to 1 on the first clock edge that samples `rx_en` = 1. When `rx_en` is 0, `running` goes to 0 at the edge where no frame is in progress. For a frame in progress, that edge is the one that takes its twelfth byte.
- R9: While `rx_en` is 0, a `frame_start` strobe does not open a frame. `s_ready` stays 0 and no verdict is produced.
- R10: After reset, `running`, `s_ready` and `verdict_valid` are 0, and all enable inputs are expected to be driven to 0.
- R11: Only bytes taken with both `s_valid` and `s_ready` high count toward the twelve. Idle cycles with `s_valid` low between bytes do not change the verdict or when it arrives relative to the last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable request |
| en_bcast | input | 1 | Accept broadcast destinations |
| en_mcast | input | 1 | Accept group-addressed destinations |
| en_ucast | input | 1 | Accept unicast destinations per the station compare |
| en_all | input | 1 | Accept every destination |
| inv_filter | input | 1 | Invert the unicast station compare |
| sa_filter | input | 1 | Drop frames whose source equals the station address |
| station_addr | input | 48 | Station address; bits 47:40 are the first byte on the wire |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| s_valid | input | 1 | Address byte valid |
| s_data | input | 8 | Address byte |
| s_ready | output | 1 | Block can take an address byte |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | 1 = keep frame, 0 = drop |
| running | output | 1 | Receiver running (1) or stopped (0) |

## Verification
- **Verdict timing:** the verdict is due exactly one clock after the edge that takes the twelfth address byte. The driver stamps each expected verdict with that due cycle when it presents the last byte. The monitor checks both the value and the cycle, and it flags any verdict that arrives with nothing expected.
- **Status timing:** `running` is checked one edge after `rx_en` is raised. A stop request raised during a frame is checked twice: `running` must still be 1 during the frame and must be 0 in the cycle the verdict appears.
- **Sampling and stimulus:** all outputs are sampled on falling edges, and inputs change only on falling edges.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic bcast;
    logic mcast;
    logic ucast;
    logic all;
    logic inverse;
    logic sa_drop;
  } filt_cfg_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic frame_start,
  input  logic in_frame,
  input  logic last_beat,
  output logic start,
  output logic running
);
  logic running_q;

  // a strobe opens a frame only while the enable is requested
  assign start   = frame_start & rx_en;
  assign running = running_q;

  // stay running until the frame in flight completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running_q <= 1'b0;
    else        running_q <= rx_en | (in_frame & ~last_beat);
  end

  AST_RUN_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> running_q); // R8
  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_q) |-> !in_frame); // R8
  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> !in_frame); // R9
endmodule

// File: rtl/rxf_collect.sv
module rxf_collect #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  localparam int TOTAL     = 2 * ADDR_BYTES,
  localparam int CW        = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          s_valid,
  input  logic [BYTE_W-1:0]             s_data,
  output logic                          s_ready,
  output logic                          in_frame,
  output logic                          last_beat,
  output logic [TOTAL-1:0][BYTE_W-1:0]  view
);
  logic                          in_frame_q;
  logic [CW-1:0]                 cnt_q;
  logic [TOTAL-1:0][BYTE_W-1:0]  bytes_q;
  logic                          beat;

  assign s_ready   = in_frame_q & ~start;
  assign beat      = s_valid & s_ready;
  assign last_beat = beat & (cnt_q == CW'(TOTAL - 1));
  assign in_frame  = in_frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (start) begin
      in_frame_q <= 1'b1;
      cnt_q      <= '0;
    end else if (last_beat) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (beat) begin
      cnt_q      <= cnt_q + 1'b1;
    end
  end

  // per-slot storage; the view carries the live byte into its slot so the
  // decision sees all addresses in the cycle of the final byte
  for (genvar i = 0; i < TOTAL; i++) begin : g_slot
    logic hit;
    assign hit = beat & (cnt_q == CW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bytes_q[i] <= '0;
      else if (hit) bytes_q[i] <= s_data;
    end
    assign view[i] = hit ? s_data : bytes_q[i];
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TOTAL - 1)); // R11
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame_q |-> cnt_q == '0); // R11
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  localparam int TOTAL     = 2 * ADDR_BYTES,
  localparam int AW        = ADDR_BYTES * BYTE_W
) (
  input  logic [TOTAL-1:0][BYTE_W-1:0] view,
  input  logic [AW-1:0]                station,
  input  filt_cfg_t                    cfg,
  output logic                         accept,
  output logic                         sa_match
);
  logic [ADDR_BYTES-1:0] d_eq, s_eq, d_ones;
  logic is_group, is_bcast, da_hit, uc_ok, addr_ok;

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_cmp
    logic [BYTE_W-1:0] st_byte;
    assign st_byte   = station[(ADDR_BYTES-1-i)*BYTE_W +: BYTE_W];
    assign d_eq[i]   = (view[i] == st_byte);
    assign s_eq[i]   = (view[ADDR_BYTES+i] == st_byte);
    assign d_ones[i] = &view[i];
  end

  assign is_group = view[0][0];
  assign is_bcast = &d_ones;
  assign da_hit   = &d_eq;
  assign sa_match = &s_eq;
  assign uc_ok    = cfg.inverse ? ~da_hit : da_hit;
  assign addr_ok  = cfg.all
                  | (is_bcast  & cfg.bcast)
                  | (is_group  & cfg.mcast)
                  | (~is_group & cfg.ucast & uc_ok);
  assign accept   = addr_ok & ~(cfg.sa_drop & sa_match);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_en,
  input  logic                         en_bcast,
  input  logic                         en_mcast,
  input  logic                         en_ucast,
  input  logic                         en_all,
  input  logic                         inv_filter,
  input  logic                         sa_filter,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
  input  logic                         frame_start,
  input  logic                         s_valid,
  input  logic [BYTE_W-1:0]            s_data,
  output logic                         s_ready,
  output logic                         verdict_valid,
  output logic                         verdict_accept,
  output logic                         running
);
  localparam int TOTAL = 2 * ADDR_BYTES;

  logic start, in_frame, last_beat, accept, sa_match;
  logic [TOTAL-1:0][BYTE_W-1:0] view;
  filt_cfg_t cfg;
  logic valid_q, accept_q;

  assign cfg = '{bcast: en_bcast, mcast: en_mcast, ucast: en_ucast,
                 all: en_all, inverse: inv_filter, sa_drop: sa_filter};

  rxf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frame_start(frame_start),
    .in_frame(in_frame), .last_beat(last_beat), .start(start), .running(running)
  );

  rxf_collect #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .in_frame(in_frame), .last_beat(last_beat), .view(view)
  );

  rxf_decide #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_decide (
    .view(view), .station(station_addr), .cfg(cfg),
    .accept(accept), .sa_match(sa_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      valid_q  <= last_beat;
      accept_q <= last_beat & accept;
    end
  end

  assign verdict_valid  = valid_q;
  assign verdict_accept = accept_q;

  AST_VERDICT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid); // R7
  AST_SA_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && sa_filter && sa_match) |=> (verdict_valid && !verdict_accept)); // R6
  AST_ALL_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && en_all && !(sa_filter && sa_match)) |=> verdict_accept); // R4
  AST_READY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> running); // R9
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 0, en_bcast = 0, en_mcast = 0, en_ucast = 0, en_all = 0;
  logic inv_filter = 0, sa_filter = 0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic frame_start = 0, s_valid = 0;
  logic [7:0] s_data = 0;
  logic s_ready, verdict_valid, verdict_accept, running;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .en_bcast(en_bcast),
    .en_mcast(en_mcast), .en_ucast(en_ucast), .en_all(en_all),
    .inv_filter(inv_filter), .sa_filter(sa_filter), .station_addr(station_addr),
    .frame_start(frame_start), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .verdict_valid(verdict_valid),
    .verdict_accept(verdict_accept), .running(running)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { bit acc; int due; string req; } exp_t;
  exp_t expq[$];

  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] OTHER = 48'h0A_BB_CC_DD_EE_01;
  localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_07;
  localparam logic [47:0] LOWB1 = 48'h00_00_00_00_00_01;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit model(input logic [47:0] d, input logic [47:0] s);
    bit grp, bc, hit, uc, ok;
    grp = d[40];
    bc  = (d == BCAST);
    hit = (d == station_addr);
    uc  = inv_filter ? !hit : hit;
    ok  = en_all | (bc & en_bcast) | (grp & en_mcast) | (!grp & en_ucast & uc);
    if (sa_filter && s == station_addr) ok = 0;
    return ok;
  endfunction

  // monitor: pops expectations as verdicts appear
  always @(negedge clk) begin
    if (rst_n && verdict_valid) begin
      if (expq.size() == 0) begin
        chk(0, "R9", "unexpected verdict", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(verdict_accept == e.acc, e.req, "verdict_accept", verdict_accept, e.acc);
        chk(cyc == e.due, "R7", "verdict cycle", cyc, e.due);
      end
    end
  end

  task automatic send(input logic [47:0] d, input logic [47:0] s,
                      input bit gaps, input int stop_at, input string req);
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
    for (int i = 0; i < 12; i++) begin
      logic [7:0] b;
      b = (i < 6) ? d[47-8*i -: 8] : s[47-8*(i-6) -: 8];
      if (gaps && (i % 3 == 1)) begin
        s_valid = 0; s_data = 8'h5A;
        @(negedge clk);
        @(negedge clk);
      end
      if (i == stop_at) rx_en = 0;
      s_valid = 1; s_data = b;
      if (i == 11) begin
        exp_t e;
        e.acc = model(d, s); e.due = cyc + 1; e.req = req;
        expq.push_back(e);
      end
      if (stop_at >= 0 && i == stop_at + 1)
        chk(running == 1, "R8", "running mid-frame after stop", running, 1);
      @(negedge clk);
    end
    s_valid = 0;
    if (stop_at >= 0) chk(running == 0, "R8", "running after frame end", running, 0);
    @(negedge clk);
  endtask

  task automatic send_ignored();
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
    for (int i = 0; i < 12; i++) begin
      s_valid = 1; s_data = 8'hFF;
      if (i == 0) chk(s_ready == 0, "R9", "s_ready while stopped", s_ready, 0);
      @(negedge clk);
    end
    s_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input bit b, m, u, a, inv, sa);
    @(negedge clk);
    en_bcast = b; en_mcast = m; en_ucast = u; en_all = a;
    inv_filter = inv; sa_filter = sa;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "R7", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(running == 0, "R10", "running in reset", running, 0);
    chk(verdict_valid == 0, "R10", "verdict_valid in reset", verdict_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(s_ready == 0, "R10", "s_ready after reset", s_ready, 0);

    // R9: stopped receiver ignores a frame
    send_ignored();
    chk(running == 0, "R9", "still stopped", running, 0);

    // R8: enable
    rx_en = 1;
    @(negedge clk);
    chk(running == 1, "R8", "running after enable", running, 1);

    // R1
    set_cfg(1, 0, 0, 0, 0, 0);
    send(BCAST, OTHER, 0, -1, "R1");
    send(station_addr, OTHER, 0, -1, "R1");
    // R2
    set_cfg(0, 1, 0, 0, 0, 0);
    send(MCAST, OTHER, 0, -1, "R2");
    send(BCAST, OTHER, 0, -1, "R2");
    send(LOWB1, OTHER, 0, -1, "R2");
    send(station_addr, OTHER, 0, -1, "R2");
    // R3
    set_cfg(0, 0, 1, 0, 0, 0);
    send(station_addr, OTHER, 0, -1, "R3");
    send(OTHER, OTHER, 0, -1, "R3");
    send(MCAST, OTHER, 0, -1, "R3");
    // R4
    set_cfg(0, 0, 0, 1, 0, 0);
    send(OTHER, OTHER, 0, -1, "R4");
    send(MCAST, station_addr, 0, -1, "R4");
    // R5
    set_cfg(0, 0, 1, 0, 1, 0);
    send(OTHER, OTHER, 0, -1, "R5");
    send(station_addr, OTHER, 0, -1, "R5");
    send(MCAST, OTHER, 0, -1, "R5");
    set_cfg(1, 0, 1, 0, 1, 0);
    send(BCAST, OTHER, 0, -1, "R5");
    // R6
    set_cfg(1, 1, 1, 1, 0, 1);
    send(station_addr, station_addr, 0, -1, "R6");
    send(BCAST, station_addr, 0, -1, "R6");
    send(station_addr, OTHER, 0, -1, "R6");
    // R11: gaps in the byte stream
    set_cfg(0, 0, 1, 0, 0, 0);
    send(station_addr, OTHER, 1, -1, "R11");
    send(OTHER, station_addr, 1, -1, "R11");
    // R8: stop request mid-frame
    send(station_addr, OTHER, 0, 5, "R8");
    send_ignored();
    // re-enable
    rx_en = 1;
    @(negedge clk);
    chk(running == 1, "R8", "running after re-enable", running, 1);
    send(station_addr, OTHER, 0, -1, "R8");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R7", "verdicts outstanding", expq.size(), 0);
    summary();
    $finish;
  end
endmodule